// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit linear address into a physical address. It does this by reading two 32-bit entries from a two-level page structure held in memory. A requester offers a linear address together with a write flag and a user flag. The walker samples the paging control register and the directory base register when it accepts the request. It then reads the directory entry and, if that entry is present, the table entry over a word-read memory port. It answers with a one-cycle response that carries either the translated physical address or a fault and its error code. Pages are 4 KB, and each table is one page holding 1024 four-byte entries. The low 12 address bits pass through as the page offset.

When the paging enable bit is clear, the walker does not touch memory and returns the linear address unchanged. Any fault copies the linear address of that request into a fault-address register. The register holds that value until the next fault or a reset. Translation caching, large pages, address extension and accessed/dirty updates are not part of the block.

The controller is a six-state machine:

- IDLE: ready for a request. ACCEPT moves to DIR_REQ when paging is on and to DONE when it is off (BYPASS).
- DIR_REQ: holds the directory read until the memory takes it (ISSUE), then moves to DIR_WAIT.
- DIR_WAIT: waits for the directory data. ABSENT moves to DONE with a fault; PRESENT moves to TBL_REQ.
- TBL_REQ: holds the table read until ISSUE, then moves to TBL_WAIT.
- TBL_WAIT: waits for the table data, then moves to DONE (RESOLVE), with or without a fault.
- DONE: presents the response for one cycle, then returns to IDLE (RETIRE).

Top module: `page_walker`

## Requirements
- R1: `req_ready` is high only in IDLE, and a request is taken on a cycle where `req_valid` and `req_ready` are both high. Each accepted request gives exactly one response cycle with `rsp_valid` high, after which `req_ready` returns high.
- R2: If bit 31 of `ctl_reg` is clear at acceptance, no memory read is issued. `rsp_valid` rises in the cycle after acceptance with `rsp_phys_addr` equal to the linear address and `rsp_fault` low.
- R3: With paging on, the first read address is {`dir_base`[31:12], linear[31:22], 2'b00}; the low 12 bits of `dir_base` are ignored.
- R4: After a present directory entry, a second read is issued at {entry[31:12], linear[21:12], 2'b00}. At most one read is outstanding, and the directory read always comes first.
- R5: A successful walk returns {table entry[31:12], linear[11:0]} with `rsp_fault` low.
- R6: Entry bit 0 is the present bit. A clear present bit at either level gives a fault with error code bit 0 = 0. An absent directory entry ends the walk with no table read.
- R7: Entry bit 1 grants write and entry bit 2 grants user access. A write request needs bit 1 set at both levels, and a user request needs bit 2 set at both levels. A violation gives a fault with error code bit 0 = 1. In every fault, error code bit 1 equals the write flag and bit 2 equals the user flag.
- R8: A fault stores the request's linear address in `fault_addr`, visible in the response cycle. A fault-free response leaves `fault_addr` unchanged.
- R9: A read request stays asserted with a stable `mem_rd_addr` until `mem_rd_ready` is high.
- R10: Reset, even in the middle of a walk, returns to IDLE with `req_ready` high, `rsp_valid` and `mem_rd_valid` low, and `fault_addr` zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Translation request offered |
| req_ready | output | 1 | Walker can take a request |
| req_lin_addr | input | 32 | Linear address to translate |
| req_write | input | 1 | Request is a write |
| req_user | input | 1 | Request is from user level |
| ctl_reg | input | 32 | Control register; bit 31 enables paging |
| dir_base | input | 32 | Directory base register; bits 31:12 used |
| mem_rd_valid | output | 1 | Memory word read requested |
| mem_rd_ready | input | 1 | Memory takes the read request |
| mem_rd_addr | output | 32 | Byte address of the entry to read |
| mem_rsp_valid | input | 1 | Read data returned |
| mem_rsp_data | input | 32 | Entry word read from memory |
| rsp_valid | output | 1 | Translation response, one cycle |
| rsp_phys_addr | output | 32 | Physical address (valid when no fault) |
| rsp_fault | output | 1 | Translation faulted |
| rsp_err_code | output | 3 | Fault code: bit0 protection, bit1 write, bit2 user |
| fault_addr | output | 32 | Linear address of the most recent fault |

## Verification
The controller state can be seen at the ports through `req_ready`, `mem_rd_valid` and `rsp_valid`. A state machine that skips or repeats a level shows up within one memory round trip as a wrong read count or a second read at the wrong address. A wrongly captured permission or present bit shows up in the response cycle as a wrong fault flag or error-code bit. A bad update of the fault-address register shows up in that same response cycle. A lost request during a memory stall shows up as an address that changes before `mem_rd_ready`, and a reset in the middle of a walk must clear every output on the next edge.

// File: rtl/pw_pkg.sv
package pw_pkg;
    typedef enum logic [2:0] {
        ST_IDLE     = 3'd0,
        ST_DIR_REQ  = 3'd1,
        ST_DIR_WAIT = 3'd2,
        ST_TBL_REQ  = 3'd3,
        ST_TBL_WAIT = 3'd4,
        ST_DONE     = 3'd5
    } pw_state_e;

    // entry attribute bit positions, decoded by the rights checker
    localparam int ENT_PRESENT = 0;
    localparam int ENT_WRITE   = 1;
    localparam int ENT_USER    = 2;
endpackage

// File: rtl/pw_addr_gen.sv
module pw_addr_gen #(
    parameter int ADDR_W = 32,
    parameter int OFF_W  = 12,
    parameter int IDX_W  = 10
) (
    input  logic [ADDR_W-OFF_W-1:0] base_frame,
    input  logic [ADDR_W-OFF_W-1:0] pde_frame,
    input  logic [IDX_W-1:0]        dir_idx,
    input  logic [IDX_W-1:0]        tbl_idx,
    input  logic                    sel_table,
    output logic [ADDR_W-1:0]       rd_addr
);
    localparam int ENT_SHIFT = OFF_W - IDX_W;
    localparam int FRAME_W   = ADDR_W - OFF_W;

    logic [FRAME_W-1:0] frame;
    logic [IDX_W-1:0]   idx;

    always_comb begin
        frame   = sel_table ? pde_frame : base_frame;
        idx     = sel_table ? tbl_idx : dir_idx;
        rd_addr = {frame, idx, {ENT_SHIFT{1'b0}}};
    end
endmodule

// File: rtl/pw_rights_check.sv
module pw_rights_check (
    input  logic [2:0] ent_bits,
    input  logic [1:0] rights_in,   // {user, write} granted by earlier level
    input  logic       req_write,
    input  logic       req_user,
    output logic       ent_absent,
    output logic       ent_denied,
    output logic [1:0] rights_out
);
    import pw_pkg::*;

    always_comb begin
        ent_absent = !ent_bits[ENT_PRESENT];
        rights_out = rights_in & {ent_bits[ENT_USER], ent_bits[ENT_WRITE]};
        ent_denied = (req_write && !rights_out[0]) || (req_user && !rights_out[1]);
    end
endmodule

// File: rtl/pw_ctrl.sv
module pw_ctrl
    import pw_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req_valid,
    input  logic pg_en,
    input  logic mem_rd_ready,
    input  logic mem_rsp_valid,
    input  logic ent_absent,
    input  logic ent_denied,
    output logic req_ready,
    output logic accept,
    output logic ev_bypass,
    output logic mem_rd_valid,
    output logic sel_table,
    output logic ev_dir_ok,
    output logic ev_done_ok,
    output logic ev_fault,
    output logic rsp_valid
);
    pw_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:     if (req_valid)     state_d = pg_en ? ST_DIR_REQ : ST_DONE;
            ST_DIR_REQ:  if (mem_rd_ready)  state_d = ST_DIR_WAIT;
            ST_DIR_WAIT: if (mem_rsp_valid) state_d = ent_absent ? ST_DONE : ST_TBL_REQ;
            ST_TBL_REQ:  if (mem_rd_ready)  state_d = ST_TBL_WAIT;
            ST_TBL_WAIT: if (mem_rsp_valid) state_d = ST_DONE;
            ST_DONE:                        state_d = ST_IDLE;
            default:                        state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        req_ready    = (state_q == ST_IDLE);
        accept       = req_ready && req_valid;
        ev_bypass    = accept && !pg_en;
        mem_rd_valid = (state_q == ST_DIR_REQ) || (state_q == ST_TBL_REQ);
        sel_table    = (state_q == ST_TBL_REQ) || (state_q == ST_TBL_WAIT);
        ev_dir_ok    = (state_q == ST_DIR_WAIT) && mem_rsp_valid && !ent_absent;
        ev_done_ok   = (state_q == ST_TBL_WAIT) && mem_rsp_valid && !ent_absent && !ent_denied;
        ev_fault     = ((state_q == ST_DIR_WAIT) && mem_rsp_valid && ent_absent) ||
                       ((state_q == ST_TBL_WAIT) && mem_rsp_valid && (ent_absent || ent_denied));
        rsp_valid    = (state_q == ST_DONE);
    end

    // R4
    rsp_expected_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rsp_valid |-> (state_q == ST_DIR_WAIT || state_q == ST_TBL_WAIT));

    // R1
    busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> !req_ready);
endmodule

// File: rtl/page_walker.sv
module page_walker #(
    parameter int ADDR_W = 32,
    parameter int OFF_W  = 12,
    parameter int IDX_W  = 10,
    parameter int PG_BIT = 31
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_lin_addr,
    input  logic              req_write,
    input  logic              req_user,
    input  logic [ADDR_W-1:0] ctl_reg,
    input  logic [ADDR_W-1:0] dir_base,
    output logic              mem_rd_valid,
    input  logic              mem_rd_ready,
    output logic [ADDR_W-1:0] mem_rd_addr,
    input  logic              mem_rsp_valid,
    input  logic [ADDR_W-1:0] mem_rsp_data,
    output logic              rsp_valid,
    output logic [ADDR_W-1:0] rsp_phys_addr,
    output logic              rsp_fault,
    output logic [2:0]        rsp_err_code,
    output logic [ADDR_W-1:0] fault_addr
);
    localparam int FRAME_W = ADDR_W - OFF_W;
    localparam int TBL_LSB = OFF_W;
    localparam int DIR_LSB = OFF_W + IDX_W;

    logic              accept, ev_bypass, ev_dir_ok, ev_done_ok, ev_fault, sel_table;
    logic              ent_absent, ent_denied;
    logic [1:0]        rights_in, rights_out;

    logic [ADDR_W-1:0]  lin_q;
    logic               wr_q, usr_q, pg_q;
    logic [FRAME_W-1:0] base_frame_q, pde_frame_q;
    logic [1:0]         rights_q;
    logic [ADDR_W-1:0]  phys_q, fault_addr_q;
    logic               fault_q;
    logic [2:0]         code_q;

    logic unused_inputs;
    assign unused_inputs = ^{ctl_reg, dir_base[OFF_W-1:0], mem_rsp_data[OFF_W-1:3]};

    pw_ctrl u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_valid    (req_valid),
        .pg_en        (ctl_reg[PG_BIT]),
        .mem_rd_ready (mem_rd_ready),
        .mem_rsp_valid(mem_rsp_valid),
        .ent_absent   (ent_absent),
        .ent_denied   (ent_denied),
        .req_ready    (req_ready),
        .accept       (accept),
        .ev_bypass    (ev_bypass),
        .mem_rd_valid (mem_rd_valid),
        .sel_table    (sel_table),
        .ev_dir_ok    (ev_dir_ok),
        .ev_done_ok   (ev_done_ok),
        .ev_fault     (ev_fault),
        .rsp_valid    (rsp_valid)
    );

    pw_addr_gen #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .IDX_W(IDX_W)) u_addr (
        .base_frame(base_frame_q),
        .pde_frame (pde_frame_q),
        .dir_idx   (lin_q[ADDR_W-1:DIR_LSB]),
        .tbl_idx   (lin_q[DIR_LSB-1:TBL_LSB]),
        .sel_table (sel_table),
        .rd_addr   (mem_rd_addr)
    );

    assign rights_in = sel_table ? rights_q : 2'b11;

    pw_rights_check u_rights (
        .ent_bits  (mem_rsp_data[2:0]),
        .rights_in (rights_in),
        .req_write (wr_q),
        .req_user  (usr_q),
        .ent_absent(ent_absent),
        .ent_denied(ent_denied),
        .rights_out(rights_out)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lin_q        <= '0;
            wr_q         <= 1'b0;
            usr_q        <= 1'b0;
            pg_q         <= 1'b0;
            base_frame_q <= '0;
            pde_frame_q  <= '0;
            rights_q     <= 2'b00;
            phys_q       <= '0;
            fault_q      <= 1'b0;
            code_q       <= 3'b000;
            fault_addr_q <= '0;
        end else begin
            if (accept) begin
                lin_q        <= req_lin_addr;
                wr_q         <= req_write;
                usr_q        <= req_user;
                pg_q         <= ctl_reg[PG_BIT];
                base_frame_q <= dir_base[ADDR_W-1:OFF_W];
            end
            if (ev_bypass) begin
                phys_q  <= req_lin_addr;
                fault_q <= 1'b0;
                code_q  <= 3'b000;
            end
            if (ev_dir_ok) begin
                pde_frame_q <= mem_rsp_data[ADDR_W-1:OFF_W];
                rights_q    <= rights_out;
            end
            if (ev_done_ok) begin
                phys_q  <= {mem_rsp_data[ADDR_W-1:OFF_W], lin_q[OFF_W-1:0]};
                fault_q <= 1'b0;
                code_q  <= 3'b000;
            end
            if (ev_fault) begin
                phys_q       <= '0;
                fault_q      <= 1'b1;
                code_q       <= {usr_q, wr_q, !ent_absent};
                fault_addr_q <= lin_q;
            end
        end
    end

    assign rsp_phys_addr = phys_q;
    assign rsp_fault     = fault_q;
    assign rsp_err_code  = code_q;
    assign fault_addr    = fault_addr_q;

    // R9
    rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_valid && !mem_rd_ready) |=> (mem_rd_valid && $stable(mem_rd_addr)));

    // R1
    rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> (!rsp_valid && req_ready));

    // R8
    fault_addr_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_fault) |-> $stable(fault_addr));

    // R2
    bypass_no_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !pg_q) |-> !rsp_fault);

    // R6
    fault_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_fault) |-> (rsp_err_code == 3'b000));
endmodule

// File: tb/tb_page_walker.sv
`timescale 1ns/1ps
module tb_page_walker;
    typedef struct packed {
        logic        pg;
        logic        wr;
        logic        usr;
        logic [31:0] lin;
        logic [31:0] pde;
        logic [31:0] pte;
        logic [3:0]  stall;
        logic [31:0] phys;
        logic        fault;
        logic [2:0]  code;
        logic [1:0]  nreads;
    } vec_t;

    localparam logic [31:0] BASE = 32'h0012_3ABC;
    localparam int NVEC = 10;
    localparam vec_t VECS [NVEC] = '{
        // R3 R5 plain read walk
        '{1'b1, 1'b0, 1'b0, 32'h1234_5678, 32'h0045_6007, 32'h0ABC_D007, 4'd0, 32'h0ABC_D678, 1'b0, 3'b000, 2'd2},
        // R2 bypass
        '{1'b0, 1'b1, 1'b1, 32'h89AB_CDEF, 32'h0000_0000, 32'h0000_0000, 4'd0, 32'h89AB_CDEF, 1'b0, 3'b000, 2'd0},
        // R6 directory entry absent, write
        '{1'b1, 1'b1, 1'b0, 32'hFFFF_F000, 32'h0045_6006, 32'h0ABC_D007, 4'd0, 32'h0000_0000, 1'b1, 3'b010, 2'd1},
        // R6 R9 table entry absent, user read, stalled memory
        '{1'b1, 1'b0, 1'b1, 32'h0040_0ABC, 32'h0045_6007, 32'h0ABC_D006, 4'd2, 32'h0000_0000, 1'b1, 3'b100, 2'd2},
        // R7 write denied at directory level
        '{1'b1, 1'b1, 1'b0, 32'h1234_5678, 32'h0045_6005, 32'h0ABC_D007, 4'd0, 32'h0000_0000, 1'b1, 3'b011, 2'd2},
        // R7 user denied at table level
        '{1'b1, 1'b0, 1'b1, 32'h1234_5678, 32'h0045_6007, 32'h0ABC_D003, 4'd0, 32'h0000_0000, 1'b1, 3'b101, 2'd2},
        // R7 user write allowed, R9 stall
        '{1'b1, 1'b1, 1'b1, 32'h0000_0FFF, 32'h0045_6007, 32'h0ABC_D007, 4'd1, 32'h0ABC_DFFF, 1'b0, 3'b000, 2'd2},
        // R7 supervisor write allowed
        '{1'b1, 1'b1, 1'b0, 32'hFFC0_0123, 32'h0045_6003, 32'h7FFF_F003, 4'd0, 32'h7FFF_F123, 1'b0, 3'b000, 2'd2},
        // R7 user read of read-only page
        '{1'b1, 1'b0, 1'b1, 32'h003F_F456, 32'h0045_6005, 32'h0ABC_D005, 4'd0, 32'h0ABC_D456, 1'b0, 3'b000, 2'd2},
        // R2 bypass of zero
        '{1'b0, 1'b0, 1'b0, 32'h0000_0000, 32'h0000_0000, 32'h0000_0000, 4'd0, 32'h0000_0000, 1'b0, 3'b000, 2'd0}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_lin_addr = '0;
    logic        req_write = 1'b0;
    logic        req_user = 1'b0;
    logic [31:0] ctl_reg = '0;
    logic [31:0] dir_base = '0;
    logic        mem_rd_valid;
    logic        mem_rd_ready = 1'b0;
    logic [31:0] mem_rd_addr;
    logic        mem_rsp_valid = 1'b0;
    logic [31:0] mem_rsp_data = '0;
    logic        rsp_valid;
    logic [31:0] rsp_phys_addr;
    logic        rsp_fault;
    logic [2:0]  rsp_err_code;
    logic [31:0] fault_addr;

    int nchecks = 0;
    int nerrors = 0;
    logic [31:0] exp_fa = '0;

    always #4 clk = ~clk;

    page_walker dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_lin_addr(req_lin_addr),
        .req_write(req_write), .req_user(req_user),
        .ctl_reg(ctl_reg), .dir_base(dir_base),
        .mem_rd_valid(mem_rd_valid), .mem_rd_ready(mem_rd_ready), .mem_rd_addr(mem_rd_addr),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
        .rsp_valid(rsp_valid), .rsp_phys_addr(rsp_phys_addr), .rsp_fault(rsp_fault),
        .rsp_err_code(rsp_err_code), .fault_addr(fault_addr)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchecks++;
        if (act !== exp) begin
            nerrors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic run_vec(input vec_t v, input int id);
        logic [31:0] addrs [2];
        logic [31:0] first_addr;
        logic [31:0] got_phys;
        logic [2:0]  got_code;
        logic        got_fault;
        int nr = 0;
        int stall;
        bit rdy_was = 0;
        bit seen = 0;
        bit got = 0;
        stall = int'(v.stall);
        addrs[0] = '0;
        addrs[1] = '0;
        first_addr = '0;
        got_phys = '0;
        got_code = '0;
        got_fault = 1'b0;
        @(negedge clk);
        check($sformatf("R1 v%0d ready before request", id), {31'd0, req_ready}, 32'd1);
        req_valid    = 1'b1;
        req_lin_addr = v.lin;
        req_write    = v.wr;
        req_user     = v.usr;
        ctl_reg      = {v.pg, 31'h0000_0011};
        dir_base     = BASE;
        for (int c = 0; c < 200 && !got; c++) begin
            @(negedge clk);
            req_valid     = 1'b0;
            mem_rsp_valid = 1'b0;
            if (c == 0)
                check($sformatf("R1 v%0d ready low while busy", id), {31'd0, req_ready}, 32'd0);
            if (rdy_was) begin
                mem_rd_ready  = 1'b0;
                mem_rsp_valid = 1'b1;
                mem_rsp_data  = (nr == 1) ? v.pde : v.pte;
                rdy_was       = 0;
            end else if (rsp_valid) begin
                got       = 1;
                got_phys  = rsp_phys_addr;
                got_fault = rsp_fault;
                got_code  = rsp_err_code;
            end else if (mem_rd_valid) begin
                if (!seen) first_addr = mem_rd_addr;
                seen = 1;
                check($sformatf("R9 v%0d address stable", id), mem_rd_addr, first_addr);
                if (stall > 0) begin
                    stall--;
                end else begin
                    if (nr < 2) addrs[nr] = mem_rd_addr;
                    nr++;
                    mem_rd_ready = 1'b1;
                    rdy_was = 1;
                    seen = 0;
                end
            end
        end
        check($sformatf("R1 v%0d response seen", id), {31'd0, got}, 32'd1);
        check($sformatf("R4 R6 v%0d read count", id), nr, {30'd0, v.nreads});
        if (nr >= 1)
            check($sformatf("R3 v%0d directory address", id), addrs[0],
                  {BASE[31:12], v.lin[31:22], 2'b00});
        if (nr >= 2)
            check($sformatf("R4 v%0d table address", id), addrs[1],
                  {v.pde[31:12], v.lin[21:12], 2'b00});
        check($sformatf("R6 R7 v%0d fault flag", id), {31'd0, got_fault}, {31'd0, v.fault});
        check($sformatf("R6 R7 v%0d error code", id), {29'd0, got_code}, {29'd0, v.code});
        if (!v.fault)
            check($sformatf("R5 R2 v%0d physical address", id), got_phys, v.phys);
        if (v.fault) exp_fa = v.lin;
        check($sformatf("R8 v%0d fault address", id), fault_addr, exp_fa);
        @(negedge clk);
        check($sformatf("R1 v%0d single response cycle", id), {31'd0, rsp_valid}, 32'd0);
        check($sformatf("R1 v%0d ready after response", id), {31'd0, req_ready}, 32'd1);
    endtask

    task automatic check_reset_state(input string when);
        check($sformatf("R10 %s req_ready", when), {31'd0, req_ready}, 32'd1);
        check($sformatf("R10 %s rsp_valid", when), {31'd0, rsp_valid}, 32'd0);
        check($sformatf("R10 %s mem_rd_valid", when), {31'd0, mem_rd_valid}, 32'd0);
        check($sformatf("R10 %s fault_addr", when), fault_addr, 32'd0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        nerrors++;
        $display("FAIL watchdog R1: actual run length over %0d cycles expected completion", 100000);
        $display("Simulation finished: %0d checks, %0d errors", nchecks, nerrors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check_reset_state("in reset");
        rst_n = 1'b1;
        @(negedge clk);
        check_reset_state("after reset");

        for (int i = 0; i < NVEC; i++) run_vec(VECS[i], i);

        // R10: reset in the middle of a walk clears the state and the fault register
        @(negedge clk);
        req_valid    = 1'b1;
        req_lin_addr = 32'h1234_5678;
        ctl_reg      = 32'h8000_0000;
        dir_base     = BASE;
        @(negedge clk);
        req_valid = 1'b0;
        check("R10 walk started", {31'd0, mem_rd_valid}, 32'd1);
        mem_rd_ready = 1'b1;
        @(negedge clk);
        mem_rd_ready = 1'b0;
        rst_n = 1'b0;
        @(negedge clk);
        check_reset_state("mid-walk reset");
        rst_n = 1'b1;
        @(negedge clk);
        check_reset_state("after mid-walk reset");
        exp_fa = '0;

        // R1 R5: a fresh walk after the reset still works
        run_vec(VECS[0], 100);

        $display("Simulation finished: %0d checks, %0d errors", nchecks, nerrors);
        $finish;
    end
endmodule